// File: doc/BRIEF.md
# Interrupt Priority In-Service Tracker

This block records which interrupt priority levels are being serviced at any moment. There are three ordered levels: power-fail is the most urgent, then high, then low. Levels nest. A low-level handler can be preempted by a high-level request, and that in turn by a power-fail request. Each level that has been entered and not yet left holds a set in-service bit.

For every level the block also gives a combinational qualifier. It says whether a request at that level would be accepted right now. Clock-management logic uses the qualifier so that only a request that can really preempt the current work may end a reduced-speed mode. Request pulses that arrive together are resolved to the most urgent one. A return pulse retires the most urgent level that is in service.

Top module: `ist_tracker`

## Requirements
- R1: After reset every in-service bit is 0 and every level is takeable.
- R2: A level is takeable exactly when no level at or above it is in service. While power-fail is in service, no level is takeable.
- R3: The low level is not takeable while the high or the power-fail level is in service.
- R4: The low level is not takeable while the low level itself is in service.
- R5: The block looks at the most urgent requested level. It accepts that level only when the level is takeable, and then `taken_o` is one-hot at that level in the same cycle. The level's in-service bit is set from the next clock edge.
- R6: A request at a level that is not takeable is ignored. `taken_o` stays 0, and without a return pulse `in_service_o` is unchanged on the next cycle.
- R7: A return pulse clears only the most urgent set in-service bit. A return pulse with nothing in service has no effect.
- R8: Nesting works: low, then high, then power-fail can all be in service together (`in_service_o` = 3'b111).
- R9: When a return pulse and an accepted request occur in the same cycle, the old most urgent level is cleared and the accepted level is set.
- R10: Bit encoding on every level vector: bit 2 is power-fail, bit 1 is high, bit 0 is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | NUM_LEVELS | Per-level request pulses (bit 2 power-fail, bit 0 low) |
| reti_i | input | 1 | Return-from-interrupt pulse |
| in_service_o | output | NUM_LEVELS | In-service flags per level |
| takeable_o | output | NUM_LEVELS | Per-level "would be accepted now" qualifier |
| taken_o | output | NUM_LEVELS | One-hot level accepted this cycle |

## Verification
The assertions assume that `req_i` and `reti_i` are sampled cleanly at each rising edge. They also assume that a return pulse stands for the retirement of the handler that is currently the most urgent one. They do not assume that a return pulse only comes while something is in service. The bench drives every input at the falling edge and holds it for a whole cycle. It includes deliberate returns with nothing in service, simultaneous multi-level requests, and a return coinciding with an accepted request. These cover the cases the properties treat specially.

// File: rtl/ist_pkg.sv
package ist_pkg;
  localparam int unsigned DEF_LEVELS = 3;
  localparam int unsigned LVL_LO = 0;
  localparam int unsigned LVL_HI = 1;
  localparam int unsigned LVL_PF = 2;
endpackage

// File: rtl/ist_msb_onehot.sv
// One-hot of the most significant set bit (bit N-1 = most urgent level).
module ist_msb_onehot #(
  parameter int unsigned N = 3
) (
  input  logic [N-1:0] vec_i,
  output logic [N-1:0] hot_o
);
  for (genvar l = 0; l < N; l++) begin : g_bit
    if (l == N - 1) begin : g_top
      assign hot_o[l] = vec_i[l];
    end else begin : g_low
      assign hot_o[l] = vec_i[l] & ~|vec_i[N-1:l+1];
    end
  end
endmodule

// File: rtl/ist_takeable.sv
// Level l may preempt only if nothing at l or above is in service.
module ist_takeable #(
  parameter int unsigned N = 3
) (
  input  logic [N-1:0] isv_i,
  output logic [N-1:0] tk_o
);
  for (genvar l = 0; l < N; l++) begin : g_lvl
    assign tk_o[l] = ~|isv_i[N-1:l];
  end
endmodule

// File: rtl/ist_state.sv
module ist_state #(
  parameter int unsigned N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         reti_i,
  input  logic [N-1:0] taken_i,
  output logic [N-1:0] isv_o
);
  logic [N-1:0] isv_q;
  logic [N-1:0] top_hot;
  logic [N-1:0] clr_mask;

  ist_msb_onehot #(.N(N)) u_top (.vec_i(isv_q), .hot_o(top_hot));

  assign clr_mask = reti_i ? top_hot : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) isv_q <= '0;
    else         isv_q <= (isv_q & ~clr_mask) | taken_i;
  end

  assign isv_o = isv_q;

  // R7: a return retires exactly one level
  a_r7_single_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reti_i && taken_i == '0 && isv_q != '0) |=>
      ($countones(isv_q) == $countones($past(isv_q)) - 1));

  a_r7_empty_return: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reti_i && taken_i == '0 && isv_q == '0) |=> (isv_q == '0));
endmodule

// File: rtl/ist_tracker.sv
module ist_tracker
  import ist_pkg::*;
#(
  parameter int unsigned NUM_LEVELS = DEF_LEVELS
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_LEVELS-1:0] req_i,
  input  logic                  reti_i,
  output logic [NUM_LEVELS-1:0] in_service_o,
  output logic [NUM_LEVELS-1:0] takeable_o,
  output logic [NUM_LEVELS-1:0] taken_o
);
  logic [NUM_LEVELS-1:0] isv;
  logic [NUM_LEVELS-1:0] tk;
  logic [NUM_LEVELS-1:0] req_top;

  ist_takeable #(.N(NUM_LEVELS)) u_tk (.isv_i(isv), .tk_o(tk));

  // Only the most urgent request competes; lower ones are dropped.
  ist_msb_onehot #(.N(NUM_LEVELS)) u_req (.vec_i(req_i), .hot_o(req_top));

  assign taken_o = req_top & tk;

  ist_state #(.N(NUM_LEVELS)) u_st (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .reti_i (reti_i),
    .taken_i(taken_o),
    .isv_o  (isv)
  );

  assign in_service_o = isv;
  assign takeable_o   = tk;

  a_r5_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(taken_o));

  a_r5_sets_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (taken_o != '0) |=> ((in_service_o & $past(taken_o)) == $past(taken_o)));

  a_r6_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (taken_o == '0 && !reti_i) |=> $stable(in_service_o));

  a_r3_low_blocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_service_o[LVL_HI] || in_service_o[LVL_PF]) |-> !takeable_o[LVL_LO]);

  a_r4_low_self: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_service_o[LVL_LO] |-> !takeable_o[LVL_LO]);

  a_r2_pf_blocks_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_service_o[LVL_PF] |-> (takeable_o == '0));
endmodule

// File: tb/sim_ist_tracker.sv
module sim_ist_tracker;
  localparam int CLK_PERIOD = 10;
  localparam int N = 3;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [N-1:0] req_i = '0;
  logic         reti_i = 1'b0;
  logic [N-1:0] in_service_o, takeable_o, taken_o;

  int checks = 0;
  int errors = 0;
  logic [N-1:0] m_isv = '0;
  logic [N-1:0] q_isv[$];
  string        q_tag[$];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  ist_tracker #(.NUM_LEVELS(N)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .reti_i(reti_i),
    .in_service_o(in_service_o), .takeable_o(takeable_o), .taken_o(taken_o)
  );

  task automatic chk(input string tag, input string what,
                     input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  // Driver: bit 2 power-fail, bit 1 high, bit 0 low (R10)
  task automatic step(input logic [N-1:0] r, input logic rt, input string tag);
    int hs = -1;
    int rh = -1;
    logic [N-1:0] e_tk, e_taken, nxt;
    @(negedge clk_i);
    req_i = r;
    reti_i = rt;
    #1;
    for (int l = 0; l < N; l++) begin
      if (m_isv[l]) hs = l;
      if (r[l]) rh = l;
    end
    for (int l = 0; l < N; l++) e_tk[l] = (l > hs);
    e_taken = (rh > hs) ? (N'(1) << rh) : '0;
    nxt = m_isv;
    if (rt && hs >= 0) nxt[hs] = 1'b0;
    nxt = nxt | e_taken;
    chk(tag, "takeable", takeable_o, e_tk);
    chk(tag, "taken", taken_o, e_taken);
    q_isv.push_back(nxt);
    q_tag.push_back(tag);
    m_isv = nxt;
  endtask

  // Monitor: compare registered state after each edge
  initial forever begin
    @(posedge clk_i);
    #(CLK_PERIOD/4);
    if (q_isv.size() > 0) begin
      logic [N-1:0] e;
      string t;
      e = q_isv.pop_front();
      t = q_tag.pop_front();
      chk(t, "in_service", in_service_o, e);
    end
  end

  initial begin
    #(CLK_PERIOD * 5000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk_i);
    chk("R1", "reset in_service", in_service_o, 3'b000);
    chk("R1", "reset takeable", takeable_o, 3'b111);
    rst_ni = 1'b1;
    step(3'b001, 1'b0, "R5");  // low accepted
    step(3'b001, 1'b0, "R4");  // low blocked by itself
    step(3'b010, 1'b0, "R5");  // high preempts
    step(3'b001, 1'b0, "R3");  // low blocked by high
    step(3'b100, 1'b0, "R8");  // full nesting
    step(3'b111, 1'b0, "R6");  // all blocked under power-fail
    step(3'b000, 1'b1, "R7");  // clears power-fail
    step(3'b000, 1'b1, "R7");  // clears high
    step(3'b000, 1'b1, "R7");  // clears low
    step(3'b000, 1'b1, "R7");  // empty return
    step(3'b011, 1'b0, "R5");  // simultaneous: high wins
    step(3'b010, 1'b0, "R6");  // high blocked by itself
    step(3'b100, 1'b1, "R9");  // return + accept
    step(3'b000, 1'b1, "R7");
    step(3'b110, 1'b0, "R2");  // power-fail wins from idle
    step(3'b000, 1'b0, "R2");  // idle under power-fail
    step(3'b000, 1'b1, "R7");
    step(3'b000, 1'b0, "R1");
    repeat (3) @(negedge clk_i);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule